// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Engine

This block holds the write-side control of a byte-wide paged nonvolatile memory. It is reached over an asynchronous static-RAM-style port with active-low chip enable, output enable and write enable, a 17-bit address and an 8-bit data bus. The data bus is split into an input, an output and an output-drive flag. The strobes are sampled on the block clock. The leading edge of each write strobe captures the address and data into an internal page latch. The host may therefore change the buses on the next cycle.

A page load collects 1 to 128 bytes that share one page address. When no further write strobe arrives within a byte-load window, a self-timed programming phase starts. It copies only the loaded bytes into the storage array. From the first captured byte until programming ends, any read returns a status byte. Its top bit is the inverse of the top bit of the last byte captured, so the host detects completion by polling. A separate 128-byte identification page sits beside the main array and is selected by a dedicated input.

Top module: `eep_page_writer`

## Requirements
- R1: A write strobe is ce_n=0, we_n=0 and oe_n=1. A read strobe is ce_n=0, oe_n=0 and we_n=1. dq_oe is 1 during a read strobe and 0 at all other times, including during a write strobe. dq_o is 0 whenever dq_oe is 0.
- R2: When the block is idle, a read returns on dq_o, in the same cycle, the stored byte at the addressed location.
- R3: The first write strobe seen while idle opens a page load. addr[16:7] selects the page and addr[6:0] selects the byte within it. Each later strobe to the same page is captured into the latch, and a repeated offset keeps the last value written.
- R4: During a page load, a write strobe whose addr[16:7] or id_sel differs from the open page is discarded. It writes nothing and does not restart the byte-load window.
- R5: Programming begins LOAD_TO clock edges after the last captured strobe. A strobe sampled on that same edge is still captured. A strobe sampled one edge later is not.
- R6: Programming lasts PROG_CYC edges. The block is idle again exactly LOAD_TO+PROG_CYC edges after the last captured strobe.
- R7: While a load or programming is pending, a read returns the inverse of bit 7 of the last captured byte in bit 7, and zeros in bits 6:0.
- R8: Write strobes during programming change neither the stored data nor the status byte.
- R9: Programming updates only the offsets captured during the load. All other bytes of that page keep their contents.
- R10: Only the low log2(STORE_PAGES) bits of the page field select storage. Pages that differ only above those bits share the same bytes.
- R11: With id_sel=1, reads and writes reach the 128-byte identification page, selected by addr[6:0] alone, and the main array is left untouched.
- R12: rst_n low returns the block to idle and discards any byte captured but not yet programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| id_sel | input | 1 | Selects the identification page |
| addr | input | 17 | Byte address: page in 16:7, offset in 6:0 |
| dq_i | input | 8 | Write data from the bus |
| dq_o | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Drive enable for dq_o |

## Verification
The byte-load window can expire on the same clock edge on which a new write strobe is sampled. The design must then capture the byte and restart the window rather than start programming. The bench provokes this by placing a second strobe exactly LOAD_TO edges after the first. It places a third strobe one edge beyond the window of the second, and it judges the outcome by reading all three offsets once programming is done. The captured byte must be present. The late one must leave the old contents in place, and the status byte polled right after it must still reflect the second byte.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_e;
endpackage

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int LOAD_TO  = 7500,
  parameter int PROG_CYC = 500000,
  parameter int PAGE_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  output eep_state_e        state_o,
  output logic [PAGE_W-1:0] prog_idx,
  output logic              commit_en
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int LIM        = (LOAD_TO > PROG_CYC) ? LOAD_TO : PROG_CYC;
  localparam int CNT_W      = $clog2(LIM + 1);

  eep_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_LOAD;
          cnt_d   = '0;
        end
      end
      ST_LOAD: begin
        if (accept) begin
          cnt_d = '0;
        end else if (cnt_q == CNT_W'(LOAD_TO - 1)) begin
          state_d = ST_PROG;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (cnt_q == CNT_W'(PROG_CYC - 1)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o   = state_q;
  assign prog_idx  = cnt_q[PAGE_W-1:0];
  assign commit_en = (state_q == ST_PROG) && (cnt_q < CNT_W'(PAGE_BYTES));
endmodule

// File: rtl/eep_page_latch.sv
module eep_page_latch #(
  parameter int ADDR_W = 17,
  parameter int PAGE_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     open_i,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     id_i,
  input  logic [DATA_W-1:0]        din_i,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic                     match_o,
  output logic [ADDR_W-PAGE_W-1:0] tag_o,
  output logic                     id_o,
  output logic [(1<<PAGE_W)-1:0]   valid_o,
  output logic [DATA_W-1:0]        rd_byte,
  output logic                     rd_valid,
  output logic                     msb_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TAG_W      = ADDR_W - PAGE_W;

  logic [TAG_W-1:0]      tag_q;
  logic                  id_q;
  logic                  msb_q;
  logic [PAGE_BYTES-1:0] valid_q, valid_d;
  logic [DATA_W-1:0]     buf_q [PAGE_BYTES];
  logic [PAGE_W-1:0]     off;

  assign off = addr_i[PAGE_W-1:0];

  always_comb begin
    valid_d = valid_q;
    if (open_i) valid_d = '0;
    if (load_i) valid_d[off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tag_q   <= '0;
      id_q    <= 1'b0;
      msb_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (open_i) begin
        tag_q <= addr_i[ADDR_W-1:PAGE_W];
        id_q  <= id_i;
      end
      if (load_i) msb_q <= din_i[DATA_W-1];
    end
  end

  for (genvar b = 0; b < PAGE_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (load_i && (off == PAGE_W'(b))) buf_q[b] <= din_i;
    end
  end

  assign match_o  = (addr_i[ADDR_W-1:PAGE_W] == tag_q) && (id_i == id_q);
  assign tag_o    = tag_q;
  assign id_o     = id_q;
  assign valid_o  = valid_q;
  assign rd_byte  = buf_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign msb_o    = msb_q;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int PAGE_W      = 7,
  parameter int DATA_W      = 8,
  parameter int STORE_PAGES = 16
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic                           wr_id,
  input  logic [$clog2(STORE_PAGES)-1:0] wr_page,
  input  logic [PAGE_W-1:0]              wr_off,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           rd_id,
  input  logic [$clog2(STORE_PAGES)-1:0] rd_page,
  input  logic [PAGE_W-1:0]              rd_off,
  output logic [DATA_W-1:0]              rd_data
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int DEPTH      = STORE_PAGES * PAGE_BYTES;

  logic [DATA_W-1:0] main_mem [DEPTH];
  logic [DATA_W-1:0] id_mem   [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (we && !wr_id) main_mem[{wr_page, wr_off}] <= wr_data;
    if (we && wr_id)  id_mem[wr_off] <= wr_data;
  end

  assign rd_data = rd_id ? id_mem[rd_off] : main_mem[{rd_page, rd_off}];
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_W      = 7,
  parameter int DATA_W      = 8,
  parameter int STORE_PAGES = 16,
  parameter int LOAD_TO     = 7500,
  parameter int PROG_CYC    = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  localparam int SP_W  = $clog2(STORE_PAGES);
  localparam int TAG_W = ADDR_W - PAGE_W;

  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic wr_now, wr_prev_q, wr_start, rd_now;
  assign wr_now = !ce_n && !we_n && oe_n;
  assign rd_now = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) wr_prev_q <= 1'b0;
    else        wr_prev_q <= wr_now;
  end
  assign wr_start = wr_now && !wr_prev_q;

  eep_state_e           state;
  logic [PAGE_W-1:0]    prog_idx;
  logic                 commit_en;
  logic                 lat_match, lat_id, lat_rd_valid, lat_msb;
  logic [TAG_W-1:0]     lat_tag;
  logic [(1<<PAGE_W)-1:0] lat_valid;
  logic [DATA_W-1:0]    lat_byte, st_rd;
  logic                 accept, open_pg, st_we, busy;

  assign open_pg = wr_start && (state == ST_IDLE);
  assign accept  = open_pg || (wr_start && (state == ST_LOAD) && lat_match);

  eep_seq #(
    .LOAD_TO (LOAD_TO),
    .PROG_CYC(PROG_CYC),
    .PAGE_W  (PAGE_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .accept   (accept),
    .state_o  (state),
    .prog_idx (prog_idx),
    .commit_en(commit_en)
  );

  eep_page_latch #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W),
    .DATA_W(DATA_W)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_q),
    .open_i  (open_pg),
    .load_i  (accept),
    .addr_i  (addr),
    .id_i    (id_sel),
    .din_i   (dq_i),
    .rd_idx  (prog_idx),
    .match_o (lat_match),
    .tag_o   (lat_tag),
    .id_o    (lat_id),
    .valid_o (lat_valid),
    .rd_byte (lat_byte),
    .rd_valid(lat_rd_valid),
    .msb_o   (lat_msb)
  );

  assign st_we = commit_en && lat_rd_valid;

  eep_store #(
    .PAGE_W     (PAGE_W),
    .DATA_W     (DATA_W),
    .STORE_PAGES(STORE_PAGES)
  ) u_store (
    .clk    (clk),
    .we     (st_we),
    .wr_id  (lat_id),
    .wr_page(lat_tag[SP_W-1:0]),
    .wr_off (prog_idx),
    .wr_data(lat_byte),
    .rd_id  (id_sel),
    .rd_page(addr[PAGE_W+SP_W-1:PAGE_W]),
    .rd_off (addr[PAGE_W-1:0]),
    .rd_data(st_rd)
  );

  assign busy = (state != ST_IDLE);

  always_comb begin
    dq_o = '0;
    if (rd_now) begin
      if (busy) dq_o = {~lat_msb, {(DATA_W-1){1'b0}}};
      else      dq_o = st_rd;
    end
  end
  assign dq_oe = rd_now;
endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk
  import eep_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int NBYTES = 128,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_q,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_o,
  input logic              wr_start,
  input logic              rd_now,
  input eep_state_e        state,
  input logic [NBYTES-1:0] valid,
  input logic [TAG_W-1:0]  tag,
  input logic              st_we
);
  assert_read_drive_R1: assert property (@(posedge clk) disable iff (!rst_q)
    dq_oe |-> (!ce_n && !oe_n && we_n));

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_q)
    !dq_oe |-> (dq_o == '0));

  assert_open_page_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_IDLE && wr_start) |=> (state == ST_LOAD && $countones(valid) == 1));

  assert_tag_hold_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_LOAD && $past(state == ST_LOAD)) |-> $stable(tag));

  assert_commit_in_prog_R6: assert property (@(posedge clk) disable iff (!rst_q)
    st_we |-> (state == ST_PROG));

  assert_prog_ignores_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_PROG && wr_start) |=> ($stable(valid) && $stable(tag)));

  assert_poll_steady_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (state == ST_PROG && $past(state == ST_PROG) && rd_now && $past(rd_now))
      |-> $stable(dq_o));
endmodule

bind eep_page_writer eep_page_writer_chk #(
  .TAG_W (ADDR_W - PAGE_W),
  .NBYTES(1 << PAGE_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rst_q   (rst_q),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .dq_oe   (dq_oe),
  .dq_o    (dq_o),
  .wr_start(wr_start),
  .rd_now  (rd_now),
  .state   (state),
  .valid   (lat_valid),
  .tag     (lat_tag),
  .st_we   (st_we)
);

// File: tb/eep_page_writer_test.sv
module eep_page_writer_test;
  localparam int CLK_NS = 10;
  localparam int LTO    = 6;
  localparam int PCY    = 140;
  localparam int SPG    = 4;
  localparam int NVEC   = 8;

  // {id_sel, addr[16:0], data[7:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 17'h00005, 8'h3C},
    {1'b0, 17'h00085, 8'hC3},
    {1'b0, 17'h1FF7F, 8'h80},
    {1'b0, 17'h0FF00, 8'h7F},
    {1'b1, 17'h00010, 8'hA5},
    {1'b0, 17'h12345, 8'h01},
    {1'b0, 17'h00100, 8'hFE},
    {1'b1, 17'h1FF7F, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, id_sel = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe;
  logic [7:0]  rv;
  int          n_vec = 0, n_bad = 0;

  eep_page_writer #(
    .STORE_PAGES(SPG),
    .LOAD_TO    (LTO),
    .PROG_CYC   (PCY)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .id_sel(id_sel), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic id, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    id_sel = id; addr = a; dq_i = d;
    oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic id, input logic [16:0] a, output logic [7:0] d);
    id_sel = id; addr = a;
    we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    d = dq_o;
    oe_n = 1'b1; ce_n = 1'b1;
    #1;
  endtask

  task automatic wait_done();
    repeat (LTO + PCY + 1) @(negedge clk);
  endtask

  function automatic logic [7:0] poll(input logic [7:0] d);
    return {~d[7], 7'b0};
  endfunction

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state, no drive with strobes idle
    repeat (2) @(negedge clk);
    chk("R1 idle no drive", {7'b0, dq_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: read strobe drives the bus, write strobe does not
    ce_n = 1'b0; oe_n = 1'b0; #1;
    chk("R1 read drives", {7'b0, dq_oe}, 8'h01);
    oe_n = 1'b1; we_n = 1'b0; #1;
    chk("R1 write no drive", {7'b0, dq_oe}, 8'h00);
    chk("R1 write quiet bus", dq_o, 8'h00);
    we_n = 1'b1; ce_n = 1'b1;
    // let the strobe edge detector see the release before the next strobe
    repeat (2) @(negedge clk);
    wait_done();

    // R2, R7, R11: vector table of single-byte page writes
    for (int i = 0; i < NVEC; i++) begin
      wr_byte(VEC[i][25], VEC[i][24:8], VEC[i][7:0]);
      rd(VEC[i][25], VEC[i][24:8], rv);
      chk("R7 poll after write", rv, poll(VEC[i][7:0]));
      wait_done();
      rd(VEC[i][25], VEC[i][24:8], rv);
      chk("R2 readback", rv, VEC[i][7:0]);
    end

    // R6: exact busy window
    wr_byte(1'b0, 17'h00200, 8'h5A);
    repeat (LTO + PCY - 1) @(negedge clk);
    rd(1'b0, 17'h00200, rv);
    chk("R6 last busy cycle", rv, 8'h80);
    @(negedge clk);
    rd(1'b0, 17'h00200, rv);
    chk("R6 first idle cycle", rv, 8'h5A);

    // R3: multi-byte load, repeated offset keeps last value
    wr_byte(1'b0, 17'h00180, 8'h10);
    wr_byte(1'b0, 17'h00181, 8'h11);
    wr_byte(1'b0, 17'h00182, 8'h12);
    wr_byte(1'b0, 17'h00183, 8'h13);
    wr_byte(1'b0, 17'h00181, 8'hE1);
    rd(1'b0, 17'h00000, rv);
    chk("R7 poll follows last byte", rv, 8'h00);
    wait_done();
    rd(1'b0, 17'h00180, rv); chk("R3 byte 0", rv, 8'h10);
    rd(1'b0, 17'h00181, rv); chk("R3 last write wins", rv, 8'hE1);
    rd(1'b0, 17'h00183, rv); chk("R3 byte 3", rv, 8'h13);

    // R9: only the loaded offset changes
    wr_byte(1'b0, 17'h00182, 8'h99);
    wait_done();
    rd(1'b0, 17'h00180, rv); chk("R9 untouched 0", rv, 8'h10);
    rd(1'b0, 17'h00182, rv); chk("R9 updated 2", rv, 8'h99);
    rd(1'b0, 17'h00183, rv); chk("R9 untouched 3", rv, 8'h13);

    // R5, R8: strobe on the expiry edge is captured, one edge later is not
    wr_byte(1'b0, 17'h00180, 8'h20);
    repeat (LTO - 2) @(negedge clk);
    wr_byte(1'b0, 17'h00182, 8'h22);
    repeat (LTO - 1) @(negedge clk);
    wr_byte(1'b0, 17'h00183, 8'hA3);
    rd(1'b0, 17'h00183, rv);
    chk("R8 poll unchanged by late strobe", rv, 8'h80);
    wait_done();
    rd(1'b0, 17'h00180, rv); chk("R5 first byte", rv, 8'h20);
    rd(1'b0, 17'h00182, rv); chk("R5 byte on expiry edge", rv, 8'h22);
    rd(1'b0, 17'h00183, rv); chk("R8 strobe in programming ignored", rv, 8'h13);

    // R4: wrong-page strobe discarded, window not restarted
    wr_byte(1'b0, 17'h00105, 8'h44);
    wait_done();
    wr_byte(1'b0, 17'h00185, 8'h55);
    wr_byte(1'b0, 17'h00105, 8'h66);
    repeat (LTO + PCY - 2) @(negedge clk);
    rd(1'b0, 17'h00185, rv); chk("R4 window not restarted", rv, 8'h55);
    rd(1'b0, 17'h00105, rv); chk("R4 other page kept", rv, 8'h44);

    // R10: page aliasing above the implemented page bits
    wr_byte(1'b0, 17'h00087, 8'h77);
    wait_done();
    rd(1'b0, 17'h00087 + 17'(SPG << 7), rv);
    chk("R10 aliased page", rv, 8'h77);

    // R11: identification page separate from main array
    wr_byte(1'b0, 17'h00003, 8'h31);
    wait_done();
    wr_byte(1'b1, 17'h00003, 8'hB2);
    wait_done();
    rd(1'b0, 17'h00003, rv); chk("R11 main untouched", rv, 8'h31);
    rd(1'b1, 17'h00003, rv); chk("R11 id page", rv, 8'hB2);
    rd(1'b1, 17'h1FF83, rv); chk("R11 page bits ignored", rv, 8'hB2);

    // R12: reset drops a pending load
    wr_byte(1'b0, 17'h00003, 8'hCC);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(1'b0, 17'h00003, rv); chk("R12 load discarded", rv, 8'h31);
    wait_done();
    rd(1'b0, 17'h00003, rv); chk("R12 nothing programmed", rv, 8'h31);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule